// File: doc/BRIEF.md
# Banked GPIO controller with edge interrupts

This block is a memory-mapped general-purpose pin controller for a pin count that is a multiple of 32, 64 by default. Software reaches it through a plain 32-bit read/write register port. For every pin it holds a direction bit, an output level that can be forced high or low one bit at a time without a read-modify-write, a synchronised read-back of the pin, independent enables for rising and falling edge capture, a sticky capture flag cleared by writing one, and a 2-bit function selector. A single level interrupt stays high while any capture flag is set.

The register space is a sequence of kinds, each kind a run of consecutive 32-bit words, one per group of 32 pins. The kinds follow in this order: level, direction, set, clear, rising enable, falling enable, capture status, function select. The function-select kind holds two words per 32-pin group (16 pins per word). A pin's driver enable, output value and function field leave the block as plain vectors for the pad ring and the pin multiplexer, which sit outside it.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset the direction, output, both edge enables, capture status and all function fields are zero, so pin_oe, pin_out, pin_alt and irq are all low.
- R2: With G = PINS/32 groups, kind index k (level 0, direction 1, set 2, clear 3, rising enable 4, falling enable 5, status 6) for group g sits at byte address (k*G + g)*4, and bit i of that word belongs to pin g*32+i; a read returns its data in reg_rdata on the clock edge that accepts the request.
- R3: Writing the set word drives pin_out high for every bit written as 1; bits written as 0 leave pin_out unchanged.
- R4: Writing the clear word drives pin_out low for every bit written as 1; bits written as 0 leave pin_out unchanged.
- R5: pin_oe follows the direction bits: 1 makes the pin an output, 0 an input; direction words read back as written.
- R6: The level word returns each pin input after a two-stage synchroniser, so a change at pin_in is readable once two rising clock edges have passed.
- R7: With a pin's rising enable set, a low-to-high change of its synchronised input sets its status bit; without the enable it does not.
- R8: With a pin's falling enable set, a high-to-low change sets its status bit; with both enables set, either direction of change sets it.
- R9: Writing 1 to a status bit clears it, writing all ones clears the whole word, and 0 bits leave status unchanged.
- R10: An edge captured on the same clock edge as a clear write to its status bit leaves the bit set.
- R11: irq is high exactly while at least one status bit in any group is set.
- R12: Function-select word j (byte address (7*G + j)*4) holds the 2-bit fields of pins j*16 to j*16+15, pin p at bits (p%16)*2+1:(p%16)*2, and drives pin_alt[2p+1:2p]; it reads back as written.
- R13: Writes to the level words are ignored, reads of the set and clear words return zero, and reads past the last function-select word return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_req | input | 1 | Register access request, one access per cycle |
| reg_we | input | 1 | 1 for write, 0 for read |
| reg_addr | input | ADDR_W | Byte address of the register word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered on the accepting edge |
| pin_in | input | PINS | Asynchronous pin inputs |
| pin_out | output | PINS | Output level per pin |
| pin_oe | output | PINS | Output enable per pin (direction) |
| pin_alt | output | 2*PINS | Function select field per pin |
| irq | output | 1 | Level interrupt, any status bit set |

## Verification
The coincidence that matters is a software clear of a status bit landing on the same clock edge as a fresh edge on that pin. The bench first sets a bit with an earlier rising edge, lets the pin fall with no falling enable, then raises the pin again and times a write-one clear so it is accepted on exactly the edge where the synchronised rise is captured, counting the two synchroniser stages and the capture register. The bit must read back as set and irq must stay high; only a second clear then empties it.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    KIND_LEVEL = 3'd0,
    KIND_DIR   = 3'd1,
    KIND_SET   = 3'd2,
    KIND_CLR   = 3'd3,
    KIND_RISE  = 3'd4,
    KIND_FALL  = 3'd5,
    KIND_STAT  = 3'd6,
    KIND_ALT   = 3'd7
  } reg_kind_e;

  typedef struct packed {
    logic      hit;
    reg_kind_e kind;
    logic [7:0] bank;
    logic      half;
  } dec_t;

  // Word index -> register kind, 32-pin group and function-select half.
  function automatic dec_t decode_word(input int unsigned word, input int unsigned nreg);
    dec_t d;
    int unsigned aw;
    d = '0;
    d.kind = KIND_LEVEL;
    if (word < 7 * nreg) begin
      d.hit  = 1'b1;
      d.kind = reg_kind_e'(3'(word / nreg));
      d.bank = 8'(word % nreg);
    end else if (word < 9 * nreg) begin
      aw     = word - 7 * nreg;
      d.hit  = 1'b1;
      d.kind = KIND_ALT;
      d.bank = 8'(aw / 2);
      d.half = aw[0];
    end
    return d;
  endfunction

  // Edges that count, given the raw transitions and the two enables.
  function automatic logic [WORD_W-1:0] qualify_edges(
    input logic [WORD_W-1:0] rise_ev,
    input logic [WORD_W-1:0] fall_ev,
    input logic [WORD_W-1:0] rise_en,
    input logic [WORD_W-1:0] fall_en
  );
    return (rise_ev & rise_en) | (fall_ev & fall_en);
  endfunction

  // Sticky status: clear-by-one, new edges win over the clear.
  function automatic logic [WORD_W-1:0] sticky_next(
    input logic [WORD_W-1:0] cur,
    input logic [WORD_W-1:0] clr,
    input logic [WORD_W-1:0] hit
  );
    return (cur & ~clr) | hit;
  endfunction

  // Output level after set and clear strobes.
  function automatic logic [WORD_W-1:0] level_next(
    input logic [WORD_W-1:0] cur,
    input logic [WORD_W-1:0] setm,
    input logic [WORD_W-1:0] clrm
  );
    return (cur | setm) & ~clrm;
  endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] rise_ev,
  output logic [WIDTH-1:0] fall_ev
);

  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
      prev_q   <= '0;
    end else begin
      stage1_q <= pin_in;
      stage2_q <= stage1_q;
      prev_q   <= stage2_q;
    end
  end

  assign level   = stage2_q;
  assign rise_ev = stage2_q & ~prev_q;
  assign fall_ev = ~stage2_q & prev_q;

endmodule

// File: rtl/gpio_bank_slice.sv
module gpio_bank_slice
  import gpio_edge_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  reg_kind_e          kind,
  input  logic               half,
  input  logic [WORD_W-1:0]  wdata,
  input  logic [WORD_W-1:0]  level,
  input  logic [WORD_W-1:0]  rise_ev,
  input  logic [WORD_W-1:0]  fall_ev,
  output logic [WORD_W-1:0]  dir_q,
  output logic [WORD_W-1:0]  out_q,
  output logic [WORD_W-1:0]  status_q,
  output logic [2*WORD_W-1:0] alt_q,
  output logic [WORD_W-1:0]  edge_hit,
  output logic [WORD_W-1:0]  set_pulse,
  output logic [WORD_W-1:0]  clr_pulse,
  output logic [WORD_W-1:0]  rd_word
);

  logic [WORD_W-1:0] rise_en_q;
  logic [WORD_W-1:0] fall_en_q;
  logic [WORD_W-1:0] stat_clr;

  assign set_pulse = (wr_en && kind == KIND_SET)  ? wdata : '0;
  assign clr_pulse = (wr_en && kind == KIND_CLR)  ? wdata : '0;
  assign stat_clr  = (wr_en && kind == KIND_STAT) ? wdata : '0;
  assign edge_hit  = qualify_edges(rise_ev, fall_ev, rise_en_q, fall_en_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q     <= '0;
      rise_en_q <= '0;
      fall_en_q <= '0;
      alt_q     <= '0;
    end else if (wr_en) begin
      case (kind)
        KIND_DIR:  dir_q     <= wdata;
        KIND_RISE: rise_en_q <= wdata;
        KIND_FALL: fall_en_q <= wdata;
        KIND_ALT: begin
          if (half) alt_q[2*WORD_W-1:WORD_W] <= wdata;
          else      alt_q[WORD_W-1:0]        <= wdata;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q    <= '0;
      status_q <= '0;
    end else begin
      out_q    <= level_next(out_q, set_pulse, clr_pulse);
      status_q <= sticky_next(status_q, stat_clr, edge_hit);
    end
  end

  always_comb begin
    case (kind)
      KIND_LEVEL: rd_word = level;
      KIND_DIR:   rd_word = dir_q;
      KIND_RISE:  rd_word = rise_en_q;
      KIND_FALL:  rd_word = fall_en_q;
      KIND_STAT:  rd_word = status_q;
      KIND_ALT:   rd_word = half ? alt_q[2*WORD_W-1:WORD_W] : alt_q[WORD_W-1:0];
      default:    rd_word = '0;
    endcase
  end

endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int PINS   = 64,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_req,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe,
  output logic [2*PINS-1:0] pin_alt,
  output logic              irq
);

  localparam int NREG = PINS / WORD_W;

  dec_t              dec;
  logic [NREG-1:0]   bank_sel;
  logic [PINS-1:0]   level_all;
  logic [PINS-1:0]   rise_all;
  logic [PINS-1:0]   fall_all;
  logic [PINS-1:0]   status_all;
  logic [PINS-1:0]   edge_all;
  logic [PINS-1:0]   set_all;
  logic [PINS-1:0]   clr_all;
  logic [WORD_W-1:0] bank_rd [NREG];
  logic [WORD_W-1:0] rd_mux;
  logic              unused_addr_lsb;

  assign unused_addr_lsb = ^reg_addr[1:0];
  assign dec = decode_word(32'(reg_addr[ADDR_W-1:2]), NREG);

  gpio_pin_sync #(.WIDTH(PINS)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_in  (pin_in),
    .level   (level_all),
    .rise_ev (rise_all),
    .fall_ev (fall_all)
  );

  for (genvar b = 0; b < NREG; b++) begin : g_bank
    assign bank_sel[b] = reg_req && dec.hit && (dec.bank == 8'(b));

    gpio_bank_slice u_slice (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (bank_sel[b] && reg_we),
      .kind      (dec.kind),
      .half      (dec.half),
      .wdata     (reg_wdata),
      .level     (level_all[b*WORD_W +: WORD_W]),
      .rise_ev   (rise_all[b*WORD_W +: WORD_W]),
      .fall_ev   (fall_all[b*WORD_W +: WORD_W]),
      .dir_q     (pin_oe[b*WORD_W +: WORD_W]),
      .out_q     (pin_out[b*WORD_W +: WORD_W]),
      .status_q  (status_all[b*WORD_W +: WORD_W]),
      .alt_q     (pin_alt[b*2*WORD_W +: 2*WORD_W]),
      .edge_hit  (edge_all[b*WORD_W +: WORD_W]),
      .set_pulse (set_all[b*WORD_W +: WORD_W]),
      .clr_pulse (clr_all[b*WORD_W +: WORD_W]),
      .rd_word   (bank_rd[b])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NREG; b++) begin
      if (dec.bank == 8'(b)) rd_mux = bank_rd[b];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
    end else if (reg_req && !reg_we) begin
      reg_rdata <= dec.hit ? rd_mux : '0;
    end
  end

  assign irq = |status_all;

endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
module gpio_edge_ctrl_chk #(
  parameter int PINS = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq,
  input logic [PINS-1:0]   pin_out,
  input logic [PINS-1:0]   status_all,
  input logic [PINS-1:0]   edge_all,
  input logic [PINS-1:0]   set_all,
  input logic [PINS-1:0]   clr_all,
  input logic [PINS/32-1:0] bank_sel
);

  AST_ONE_GROUP_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_sel)); // R2

  AST_SET_RAISES_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (set_all != '0) |=> ((pin_out & $past(set_all)) == $past(set_all))); // R3

  AST_OUTPUT_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (set_all == '0 && clr_all == '0) |=> $stable(pin_out)); // R3

  AST_CLEAR_LOWERS_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_all != '0) |=> ((pin_out & $past(clr_all)) == '0)); // R4

  AST_STATUS_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_all & ~$past(status_all) & ~$past(edge_all)) == '0)); // R7

  AST_EDGE_NOT_LOST: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_all != '0) |=> ((status_all & $past(edge_all)) == $past(edge_all))); // R10

  AST_IRQ_FROM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(edge_all != '0)); // R11

endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(.PINS(PINS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq        (irq),
  .pin_out    (pin_out),
  .status_all (status_all),
  .edge_all   (edge_all),
  .set_all    (set_all),
  .clr_all    (clr_all),
  .bank_sel   (bank_sel)
);

// File: tb/gpio_edge_ctrl_test.sv
`timescale 1ns/1ps
module gpio_edge_ctrl_test;

  localparam int PINS   = 64;
  localparam int ADDR_W = 8;
  localparam int GRP    = PINS / 32;

  logic              clk;
  logic              rst_n;
  logic              reg_req;
  logic              reg_we;
  logic [ADDR_W-1:0] reg_addr;
  logic [31:0]       reg_wdata;
  logic [31:0]       reg_rdata;
  logic [PINS-1:0]   pin_in;
  logic [PINS-1:0]   pin_out;
  logic [PINS-1:0]   pin_oe;
  logic [2*PINS-1:0] pin_alt;
  logic              irq;

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] v;

  gpio_edge_ctrl #(.PINS(PINS), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .pin_alt(pin_alt), .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Byte address: each kind occupies GRP words, one word per 32 pins.
  function automatic int addr_of(input int kind, input int grp);
    int stride = GRP * 4;
    return kind * stride + grp * 4;
  endfunction

  function automatic int alt_addr(input int word);
    return 7 * GRP * 4 + word * 4;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_req = 1'b1; reg_we = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = d;
    @(negedge clk);
    reg_req = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_req = 1'b1; reg_we = 1'b0; reg_addr = ADDR_W'(a);
    @(negedge clk);
    reg_req = 1'b0;
    d = reg_rdata;
  endtask

  task automatic settle3();
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    check(pin_oe == '0 && pin_out == '0, "R1 oe/out", {pin_oe[31:0], pin_out[31:0]}, 64'h0);
    check(pin_alt == '0 && irq == 1'b0, "R1 alt/irq", {pin_alt[62:0], irq}, 64'h0);
    rd(addr_of(6, 1), v); check(v == 32'h0, "R1 status", 64'(v), 64'h0);
    rd(addr_of(4, 0), v); check(v == 32'h0, "R1 rise enable", 64'(v), 64'h0);
  endtask

  task automatic t_dir();
    wr(addr_of(1, 0), 32'h0000_F00F);
    wr(addr_of(1, 1), 32'h8000_0001);
    rd(addr_of(1, 0), v); check(v == 32'h0000_F00F, "R2 dir group0", 64'(v), 64'h0000_F00F);
    rd(addr_of(1, 1), v); check(v == 32'h8000_0001, "R2 dir group1", 64'(v), 64'h8000_0001);
    check(pin_oe == 64'h8000_0001_0000_F00F, "R5 pin_oe", pin_oe, 64'h8000_0001_0000_F00F);
  endtask

  task automatic t_set_clear();
    wr(addr_of(2, 1), 32'h0000_0300);
    check(pin_out == 64'h0000_0300_0000_0000, "R3 set", pin_out, 64'h0000_0300_0000_0000);
    wr(addr_of(2, 0), 32'h0);
    check(pin_out == 64'h0000_0300_0000_0000, "R3 zero set", pin_out, 64'h0000_0300_0000_0000);
    wr(addr_of(3, 1), 32'h0000_0100);
    check(pin_out == 64'h0000_0200_0000_0000, "R4 clear", pin_out, 64'h0000_0200_0000_0000);
    wr(addr_of(3, 1), 32'h0);
    check(pin_out == 64'h0000_0200_0000_0000, "R4 zero clear", pin_out, 64'h0000_0200_0000_0000);
    rd(addr_of(2, 1), v); check(v == 32'h0, "R13 set reads zero", 64'(v), 64'h0);
    rd(addr_of(3, 1), v); check(v == 32'h0, "R13 clear reads zero", 64'(v), 64'h0);
  endtask

  task automatic t_level();
    @(negedge clk);
    pin_in = 64'h1234_5678_9ABC_DEF0;
    repeat (2) @(negedge clk);
    rd(addr_of(0, 0), v); check(v == 32'h9ABC_DEF0, "R6 level group0", 64'(v), 64'h9ABC_DEF0);
    rd(addr_of(0, 1), v); check(v == 32'h1234_5678, "R6 level group1", 64'(v), 64'h1234_5678);
    wr(addr_of(0, 0), 32'hFFFF_FFFF);
    rd(addr_of(0, 0), v); check(v == 32'h9ABC_DEF0, "R13 level write ignored", 64'(v), 64'h9ABC_DEF0);
    rd(addr_of(6, 0), v); check(v == 32'h0, "R7 no capture without enable", 64'(v), 64'h0);
    @(negedge clk);
    pin_in = '0;
    settle3();
  endtask

  task automatic t_rise();
    wr(addr_of(4, 0), 32'h0000_0008);
    @(negedge clk);
    pin_in[3] = 1'b1; pin_in[5] = 1'b1;
    settle3();
    rd(addr_of(6, 0), v); check(v == 32'h0000_0008, "R7 rising capture", 64'(v), 64'h8);
    check(irq == 1'b1, "R11 irq high", 64'(irq), 64'h1);
    wr(addr_of(6, 0), 32'h0);
    rd(addr_of(6, 0), v); check(v == 32'h0000_0008, "R9 zero write keeps", 64'(v), 64'h8);
    wr(addr_of(6, 0), 32'h0000_0008);
    rd(addr_of(6, 0), v); check(v == 32'h0, "R9 write one clears", 64'(v), 64'h0);
    check(irq == 1'b0, "R11 irq low", 64'(irq), 64'h0);
  endtask

  task automatic t_fall();
    wr(addr_of(5, 1), 32'h0000_000C);
    wr(addr_of(4, 1), 32'h0000_0008);
    @(negedge clk);
    pin_in[34] = 1'b1; pin_in[35] = 1'b1;
    settle3();
    rd(addr_of(6, 1), v); check(v == 32'h0000_0008, "R8 rise with both enables", 64'(v), 64'h8);
    wr(addr_of(6, 1), 32'h0000_0008);
    @(negedge clk);
    pin_in[34] = 1'b0; pin_in[35] = 1'b0;
    settle3();
    rd(addr_of(6, 1), v); check(v == 32'h0000_000C, "R8 falling capture", 64'(v), 64'hC);
    check(irq == 1'b1, "R11 irq from group1", 64'(irq), 64'h1);
    wr(addr_of(6, 1), 32'hFFFF_FFFF);
    rd(addr_of(6, 1), v); check(v == 32'h0, "R9 clear whole word", 64'(v), 64'h0);
  endtask

  task automatic t_collide();
    wr(addr_of(4, 0), 32'h0000_0408);
    @(negedge clk);
    pin_in[10] = 1'b1;
    settle3();
    rd(addr_of(6, 0), v); check(v == 32'h0000_0400, "R10 first capture", 64'(v), 64'h400);
    @(negedge clk);
    pin_in[10] = 1'b0;
    settle3();
    // Raise again and land the clear on the edge that captures the rise.
    pin_in[10] = 1'b1;
    @(negedge clk);
    wr(addr_of(6, 0), 32'h0000_0400);
    rd(addr_of(6, 0), v); check(v == 32'h0000_0400, "R10 edge beats clear", 64'(v), 64'h400);
    check(irq == 1'b1, "R10 irq kept", 64'(irq), 64'h1);
    wr(addr_of(6, 0), 32'h0000_0400);
    rd(addr_of(6, 0), v); check(v == 32'h0, "R10 later clear", 64'(v), 64'h0);
  endtask

  task automatic t_alt();
    wr(alt_addr(3), 32'h0000_0006);
    check(pin_alt[97:96] == 2'd2 && pin_alt[99:98] == 2'd1, "R12 fields pins 48/49",
          64'(pin_alt[99:96]), 64'h6);
    rd(alt_addr(3), v); check(v == 32'h0000_0006, "R12 readback", 64'(v), 64'h6);
    wr(alt_addr(0), 32'hC000_0000);
    check(pin_alt[31:30] == 2'd3 && pin_alt[29:0] == '0, "R12 pin 15 field",
          64'(pin_alt[31:0]), 64'hC000_0000);
    rd(alt_addr(4), v); check(v == 32'h0, "R13 past end", 64'(v), 64'h0);
    rd(200, v); check(v == 32'h0, "R13 far address", 64'(v), 64'h0);
  endtask

  initial begin
    #(8 * 20000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_req = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    pin_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_dir();
    t_set_clear();
    t_level();
    t_rise();
    t_fall();
    t_collide();
    t_alt();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule